// File: doc/BRIEF.md
# Dual 12-bit Serial DAC Register

This block models the digital side of a dual-channel 12-bit DAC that sits in a daisy chain of serial devices. A controller lowers the active-low select line, clocks a 16-bit command word in MSB first on rising serial-clock edges, and raises select again. On that release the block decodes the word. The word can do nothing, force the device into its default output mode, or load one of two 12-bit channel codes.

The serial output passes the bit that drops out of the far end of the 16-bit shift register to the next device in the chain. A bit therefore reappears 16 serial clocks after it entered. In normal mode the output changes on the rising serial-clock edge. After a default-mode command it changes on the falling edge instead. The select, serial-clock and data inputs are taken as already synchronous to the system clock. Edges are found by comparing each input with its value one system clock earlier.

Top module: `serial_dual_dac`

## Requirements
- R1: After reset both channel codes are 0, the default-mode flag is 0 and the serial output is 0.
- R2: The word is taken MSB first. Bits [15:13] are the address and control field, bits [12:1] the 12-bit code, and bit 0 a trailing bit that is ignored. Field value 3'b010 loads the code into channel A.
- R3: Field value 3'b110 loads the code into channel B.
- R4: The channels change only in the system clock after select rises. Serial-clock edges while select is high shift nothing and leave the serial output unchanged.
- R5: Field 3'b000 with word bit 12 at 0 is a no-operation: both channels and the mode flag keep their values.
- R6: Field 3'b000 with word bits [12:9] = 4'b1000 sets the default-mode flag and leaves both channels unchanged. Once set, the flag stays set until reset.
- R7: Any other word leaves both channels and the mode flag unchanged. This covers fields 001, 011, 100, 101 and 111, and field 000 with bits [12:9] other than 0xxx or 1000.
- R8: In normal mode the serial output changes only on a rising serial-clock edge under select. It then equals the bit shifted in 16 rising edges earlier; bits still held in the register since reset count as 0.
- R9: In default mode the serial output holds its value across a rising edge. On the next falling edge it takes the bit that left the register on that rising edge.
- R10: At most one channel changes per word. If more than 16 bits are shifted, only the last 16 are decoded. Every code from 0 to 4095 loads exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Select, active low; its rising edge commits the word |
| sclk | input | 1 | Serial clock; shifts on its rising edge |
| din | input | 1 | Serial data in |
| dout | output | 1 | Serial data out to the next device in the chain |
| code_a | output | 12 | Channel A code |
| code_b | output | 12 | Channel B code |
| default_mode | output | 1 | Set once a default-mode command has been committed |

## Verification
The assertions check on every cycle the following properties:
- a channel code changes only right after a select release, and never both at once;
- the mode flag never drops;
- the serial output moves only after a serial-clock edge;
- in default mode the serial output is frozen across a rising edge.

Only the bench's scenarios can show the rest:
- that the right code lands in the right channel across the code range;
- that each undecoded pattern is truly ignored;
- that the output stream is the input stream delayed by exactly 16 bits;
- that extra leading bits are dropped.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_DEFAULT = 2'd1,
        OP_LOAD_A  = 2'd2,
        OP_LOAD_B  = 2'd3
    } sdac_op_e;

    localparam int CTL_W = 3;
endpackage

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              slow_out,
    output logic [WORD_W-1:1] word,
    output logic              word_done,
    output logic              dout
);
    typedef struct packed {
        logic              sclk;
        logic              cs;
        logic [WORD_W-1:0] sreg;
        logic              leave;
        logic              dout;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      rise, fall;

    always_comb begin
        rise      = sclk & ~st_q.sclk & ~cs_n;
        fall      = ~sclk & st_q.sclk & ~cs_n;
        word_done = cs_n & ~st_q.cs;
        st_d      = st_q;
        st_d.sclk = sclk;
        st_d.cs   = cs_n;
        if (rise) begin
            st_d.sreg  = {st_q.sreg[WORD_W-2:0], din};
            st_d.leave = st_q.sreg[WORD_W-1];
            if (!slow_out) begin
                st_d.dout = st_q.sreg[WORD_W-1];
            end
        end
        if (fall && slow_out) begin
            st_d.dout = st_q.leave;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cs    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.sreg[WORD_W-1:1];
    assign dout = st_q.dout;

    assert_dout_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dout != $past(st_q.dout)) |-> ($past(rise) || $past(fall)));

    assert_dflt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && slow_out) |=> (st_q.dout == $past(st_q.dout)));
endmodule

// File: rtl/sdac_decode.sv
module sdac_decode
    import sdac_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int WORD_W = CODE_W + 4
) (
    input  logic [WORD_W-1:1] word,
    output sdac_op_e          op,
    output logic [CODE_W-1:0] code
);
    logic [CTL_W-1:0] ctl;

    always_comb begin
        ctl  = word[WORD_W-1 -: CTL_W];
        code = word[CODE_W:1];
        op   = OP_NONE;
        unique case (ctl)
            3'b010:  op = OP_LOAD_A;
            3'b110:  op = OP_LOAD_B;
            3'b000:  op = (code[CODE_W-1 -: 4] == 4'b1000) ? OP_DEFAULT : OP_NONE;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/serial_dual_dac.sv
module serial_dual_dac
    import sdac_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              default_mode
);
    localparam int WORD_W = CODE_W + 4;

    typedef struct packed {
        logic [CODE_W-1:0] a;
        logic [CODE_W-1:0] b;
        logic              dflt;
    } chan_st_t;

    chan_st_t          st_d, st_q;
    logic [WORD_W-1:1] word;
    logic              word_done;
    sdac_op_e          op;
    logic [CODE_W-1:0] code;

    sdac_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .din       (din),
        .slow_out  (st_q.dflt),
        .word      (word),
        .word_done (word_done),
        .dout      (dout)
    );

    sdac_decode #(.CODE_W(CODE_W), .WORD_W(WORD_W)) u_dec (
        .word (word),
        .op   (op),
        .code (code)
    );

    always_comb begin
        st_d = st_q;
        if (word_done) begin
            unique case (op)
                OP_LOAD_A:  st_d.a    = code;
                OP_LOAD_B:  st_d.b    = code;
                OP_DEFAULT: st_d.dflt = 1'b1;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_a       = st_q.a;
    assign code_b       = st_q.b;
    assign default_mode = st_q.dflt;

    assert_load_on_release_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.a != $past(st_q.a)) |-> $past(word_done));

    assert_load_on_release_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.b != $past(st_q.b)) |-> $past(word_done));

    assert_one_channel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !((st_q.a != $past(st_q.a)) && (st_q.b != $past(st_q.b))));

    assert_mode_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(st_q.dflt));
endmodule

// File: tb/serial_dual_dac_bench.sv
module serial_dual_dac_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        dout;
    logic [11:0] code_a, code_b;
    logic        default_mode;

    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    logic [15:0] m_sreg = '0;
    logic        m_dout = 1'b0;
    logic [11:0] m_a = '0;
    logic [11:0] m_b = '0;
    logic        m_dflt = 1'b0;

    serial_dual_dac u_serial_dual_dac (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk), .din (din),
        .dout (dout), .code_a (code_a), .code_b (code_b), .default_mode (default_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait2();
        repeat (2) @(negedge clk);
    endtask

    task automatic check_chans(input string tag);
        chk({tag, " code_a"}, code_a, m_a);
        chk({tag, " code_b"}, code_b, m_b);
        chk({tag, " mode"}, default_mode, m_dflt);
    endtask

    // one serial bit under select; checks R8 (normal) or R9 (default)
    task automatic put_bit(input logic b);
        logic leaving;
        leaving = m_sreg[15];
        m_sreg  = {m_sreg[14:0], b};
        din  = b;
        sclk = 1'b1;
        wait2();
        if (!m_dflt) begin
            m_dout = leaving;
            chk("R8 dout after rise", dout, m_dout);
        end else begin
            chk("R9 dout held over rise", dout, m_dout);
        end
        chk("R4 code_a stable mid-word", code_a, m_a);
        sclk = 1'b0;
        wait2();
        if (m_dflt) begin
            m_dout = leaving;
            chk("R9 dout after fall", dout, m_dout);
        end else begin
            chk("R8 dout held over fall", dout, m_dout);
        end
    endtask

    task automatic send(input logic [31:0] w, input int n);
        logic [11:0] c;
        cs_n = 1'b0;
        wait2();
        for (int i = n - 1; i >= 0; i--) put_bit(w[i]);
        cs_n = 1'b1;
        c = m_sreg[12:1];
        case (m_sreg[15:13])
            3'b010: m_a = c;
            3'b110: m_b = c;
            3'b000: if (c[11:8] == 4'b1000) m_dflt = 1'b1;
            default: ;
        endcase
        wait2();
    endtask

    function automatic logic [31:0] mk(input logic [2:0] ctl, input logic [11:0] c);
        return {16'd0, ctl, c, 1'b0};
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait2();
        rst_n = 1'b1;
        wait2();
        // R1 reset state
        check_chans("R1 reset");
        chk("R1 dout reset", dout, 0);

        // R2 / R3 / R10 sweep over the code range, alternating channels
        for (int c = 0; c < 4096; c += 13) begin
            send(mk(3'b010, 12'(c)), 16);
            check_chans("R2 load A");
            send(mk(3'b110, 12'(4095 - c)), 16);
            check_chans("R3 load B");
        end
        send(mk(3'b010, 12'd4095), 16);
        check_chans("R10 max code A");
        send(mk(3'b110, 12'd0), 16);
        check_chans("R10 min code B");

        // R5 no-operation words
        send(mk(3'b000, 12'h000), 16);
        check_chans("R5 nop zero");
        send(mk(3'b000, 12'h7FF), 16);
        check_chans("R5 nop ones");

        // R7 undecoded words
        send(mk(3'b001, 12'h123), 16);
        check_chans("R7 ctl001");
        send(mk(3'b011, 12'h456), 16);
        check_chans("R7 ctl011");
        send(mk(3'b100, 12'h789), 16);
        check_chans("R7 ctl100");
        send(mk(3'b101, 12'hABC), 16);
        check_chans("R7 ctl101");
        send(mk(3'b111, 12'hDEF), 16);
        check_chans("R7 ctl111");
        send(mk(3'b000, 12'h9FF), 16);
        check_chans("R7 ctl000 1001");
        send(mk(3'b000, 12'hC00), 16);
        check_chans("R7 ctl000 1100");

        // R10 longer frame: only the last 16 bits count
        send({12'h0, 4'b1100, mk(3'b010, 12'h5A5)} , 20);
        check_chans("R10 long frame");

        // R4 serial clocks with select high are ignored
        for (int i = 0; i < 5; i++) begin
            din  = 1'(i);
            sclk = 1'b1;
            wait2();
            chk("R4 dout idle rise", dout, m_dout);
            sclk = 1'b0;
            wait2();
            chk("R4 dout idle fall", dout, m_dout);
        end
        send(mk(3'b110, 12'h3C3), 16);
        check_chans("R4 after idle clocks");

        // R6 enter default mode; R9 then governs dout
        send(mk(3'b000, 12'h8AB), 16);
        check_chans("R6 default cmd");
        chk("R6 mode set", default_mode, 1);
        send(mk(3'b010, 12'hF0F), 16);
        check_chans("R9 load in default mode");
        send(mk(3'b000, 12'h000), 16);
        check_chans("R6 mode sticky");
        send(mk(3'b110, 12'h0F0), 16);
        check_chans("R9 load B in default mode");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule